// File: doc/BRIEF.md
# Byte-stream frame synchronizer

This block watches a stream of bytes, one byte per cycle in which the strobe `in_valid` is high. It locks onto fixed-length frames. The first byte of every frame carries a sync value that is set at run time. After reset the block hunts for that value. Once it finds it, the block counts each frame byte and expects the next sync byte exactly `frame_len` bytes after the previous one. The count includes the sync byte itself.

A sync byte that arrives too early is flagged as an error, and the frame restarts from that byte. A byte at the expected start position that is not the sync value is also flagged, and the block drops back to hunting. The next sync byte it finds after such a loss is counted as a late sync, which is one more error, and the block realigns to it. Two saturating counters keep totals: one for sync bytes seen and one for framing errors.

All outputs are registered. A pulse appears in the cycle after the clock edge that sampled the causing byte and lasts one cycle. Both counters change at that same edge.

Top module: `bsync_framer`

## Requirements
- R1: After synchronous reset (`rst` high), all pulses are low, both counters read 0, and the block is hunting.
- R2: While hunting, a non-sync byte produces no pulse and changes no counter. The first sync byte found sets `frame_start`, adds 1 to `sync_count`, and raises no error, unless R5 applies.
- R3: While locked, bytes 2 to `frame_len` of a frame each raise `payload_valid`. A sync byte at position `frame_len`+1 raises `frame_start` without an error and starts a new frame.
- R4: While locked, a non-sync byte at the expected frame-start position raises `frame_err` and adds 1 to `err_count`. The block then returns to hunting, so the bytes that follow give no `payload_valid`.
- R5: The first sync byte found after a loss (R4) raises `frame_start` and `frame_err` together. It adds 1 to both counters and realigns the frame count to that byte.
- R6: While locked, a sync byte before the expected frame-start position raises `frame_err` and `frame_start`. It adds 1 to both counters and restarts the frame count from that byte.
- R7: `sync_count` counts every sync byte detected while the length is valid, whether the block is hunting or locked.
- R8: Both counters are 16 bits wide and hold at 16'hFFFF instead of wrapping.
- R9: A `frame_len` of 0 or 1 is invalid. The block then stays hunting, gives no pulse, and counts nothing, even for sync bytes.
- R10: The block advances only on cycles where `in_valid` is high. A cycle with `in_valid` low gives no pulse and leaves the frame position unchanged.
- R11: The sync value can be changed at run time. Detection uses the value of `sync_value` sampled with each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Incoming byte |
| sync_value | input | 8 | Byte value that marks a frame start |
| frame_len | input | 8 | Frame length in bytes, sync byte included |
| frame_start | output | 1 | Pulse: a sync byte was accepted |
| payload_valid | output | 1 | Pulse: a payload byte was accepted while locked |
| frame_err | output | 1 | Pulse: misplaced or missing sync |
| sync_count | output | 16 | Saturating count of sync bytes |
| err_count | output | 16 | Saturating count of framing errors |

## Verification
The hardest case to reach is counter saturation. Reaching it needs 65535 framing errors. The bench gets there by setting the longest frame length and sending nothing but sync bytes, so that every strobe after lock is an early sync. Each of those strobes raises both counters by one. About 65.5k strobes therefore bring both counters to the limit, and a few extra strobes show that they hold there.

The late-sync case is harder to reach than the early one. It needs a lost lock first, then hunting bytes, and only then the sync byte. The bench builds that sequence on purpose, and it adds idle cycles inside frames to show that gaps in the strobe do not move the frame position.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
   typedef enum logic {
      SB_HUNT = 1'b0,
      SB_LOCK = 1'b1
   } sb_state_e;
endpackage

// File: rtl/bsync_sat_counter.sv
module bsync_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial assert (CNT_W >= 2) else $error("bsync_sat_counter: CNT_W must be at least 2");

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   // R7
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R10
   no_inc_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q));
endmodule

// File: rtl/bsync_tracker.sv
module bsync_tracker
   import bsync_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic [DATA_W-1:0] sync_value,
   input  logic [LEN_W-1:0]  frame_len,
   output logic              sync_hit,
   output logic              err_hit,
   output logic              frame_start_o,
   output logic              payload_o,
   output logic              frame_err_o
);
   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

   initial assert (LEN_W >= 2 && DATA_W >= 1) else $error("bsync_tracker: bad widths");

   sb_state_e        state_q, state_d;
   logic [LEN_W-1:0] pos_q, pos_d;
   logic             late_q, late_d;
   logic             start_d, pay_d, err_d;
   logic             is_sync, len_ok, at_end;

   assign is_sync = (in_byte == sync_value);
   assign len_ok  = (frame_len >= MIN_LEN);
   assign at_end  = (pos_q >= frame_len);

   always_comb begin
      state_d = state_q;
      pos_d   = pos_q;
      late_d  = late_q;
      start_d = 1'b0;
      pay_d   = 1'b0;
      err_d   = 1'b0;
      if (in_valid) begin
         if (!len_ok) begin
            state_d = SB_HUNT;
            pos_d   = '0;
            late_d  = 1'b0;
         end else begin
            unique case (state_q)
               SB_HUNT: begin
                  if (is_sync) begin
                     start_d = 1'b1;
                     err_d   = late_q;
                     late_d  = 1'b0;
                     state_d = SB_LOCK;
                     pos_d   = ONE;
                  end
               end
               SB_LOCK: begin
                  if (at_end) begin
                     if (is_sync) begin
                        start_d = 1'b1;
                        pos_d   = ONE;
                     end else begin
                        err_d   = 1'b1;
                        late_d  = 1'b1;
                        state_d = SB_HUNT;
                        pos_d   = '0;
                     end
                  end else if (is_sync) begin
                     start_d = 1'b1;
                     err_d   = 1'b1;
                     pos_d   = ONE;
                  end else begin
                     pay_d = 1'b1;
                     pos_d = pos_q + 1'b1;
                  end
               end
               default: state_d = SB_HUNT;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q       <= SB_HUNT;
         pos_q         <= '0;
         late_q        <= 1'b0;
         frame_start_o <= 1'b0;
         payload_o     <= 1'b0;
         frame_err_o   <= 1'b0;
      end else begin
         state_q       <= state_d;
         pos_q         <= pos_d;
         late_q        <= late_d;
         frame_start_o <= start_d;
         payload_o     <= pay_d;
         frame_err_o   <= err_d;
      end
   end

   assign sync_hit = start_d;
   assign err_hit  = err_d;

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!frame_start_o && !payload_o && !frame_err_o));

   // R10
   idle_pos_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(pos_q));

   // R9
   bad_len_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !len_ok) |=> (!frame_start_o && !payload_o && !frame_err_o && state_q == SB_HUNT));

   // R2
   hunt_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SB_HUNT && in_valid && !is_sync) |=> (!frame_start_o && !payload_o && !frame_err_o));

   // R4
   loss_to_hunt_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SB_LOCK && in_valid && len_ok && at_end && !is_sync) |=> (frame_err_o && state_q == SB_HUNT));

   // R3
   pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({frame_start_o, payload_o}));
endmodule

// File: rtl/bsync_framer.sv
module bsync_framer #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic [DATA_W-1:0] sync_value,
   input  logic [LEN_W-1:0]  frame_len,
   output logic              frame_start,
   output logic              payload_valid,
   output logic              frame_err,
   output logic [CNT_W-1:0]  sync_count,
   output logic [CNT_W-1:0]  err_count
);
   localparam int N_CNT = 2;

   logic             sync_hit, err_hit;
   logic [N_CNT-1:0] inc_vec;
   logic [CNT_W-1:0] cnt_vec [N_CNT];

   bsync_tracker #(
      .DATA_W(DATA_W),
      .LEN_W (LEN_W)
   ) trk_i (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .sync_value   (sync_value),
      .frame_len    (frame_len),
      .sync_hit     (sync_hit),
      .err_hit      (err_hit),
      .frame_start_o(frame_start),
      .payload_o    (payload_valid),
      .frame_err_o  (frame_err)
   );

   assign inc_vec = {err_hit, sync_hit};

   for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
      bsync_sat_counter #(.CNT_W(CNT_W)) cnt_i (
         .clk  (clk),
         .rst  (rst),
         .inc  (inc_vec[gi]),
         .cnt_o(cnt_vec[gi])
      );
   end

   assign sync_count = cnt_vec[0];
   assign err_count  = cnt_vec[1];

   // R5
   err_counted_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_err && $past(err_count) != '1) |-> (err_count == $past(err_count) + 1'b1));

   // R7
   start_counted_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_start && $past(sync_count) != '1) |-> (sync_count == $past(sync_count) + 1'b1));
endmodule

// File: tb/bsync_framer_tb_top.sv
`timescale 1ns/1ps
module bsync_framer_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic [7:0]  sync_value = 8'hA5;
   logic [7:0]  frame_len = 8'd4;
   logic        frame_start, payload_valid, frame_err;
   logic [15:0] sync_count, err_count;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   bsync_framer dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .sync_value(sync_value), .frame_len(frame_len),
      .frame_start(frame_start), .payload_valid(payload_valid), .frame_err(frame_err),
      .sync_count(sync_count), .err_count(err_count)
   );

   // behavioural reference
   bit          m_locked = 0;
   int          m_pos = 0;
   bit          m_late = 0;
   bit          e_start = 0, e_pay = 0, e_err = 0;
   int          e_sc = 0, e_ec = 0;
   string       tag = "R1";

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v == 16'hFFFF) ? v : v + 1;
   endfunction

   task automatic model(input bit r, input bit v, input logic [7:0] b);
      e_start = 0; e_pay = 0; e_err = 0;
      if (r) begin
         m_locked = 0; m_pos = 0; m_late = 0; e_sc = 0; e_ec = 0; tag = "R1";
      end else if (!v) begin
         tag = "R10";
      end else if (frame_len < 2) begin
         m_locked = 0; m_pos = 0; m_late = 0; tag = "R9";
      end else if (!m_locked) begin
         if (b == sync_value) begin
            e_start = 1; e_sc = sat_inc(e_sc);
            if (m_late) begin e_err = 1; e_ec = sat_inc(e_ec); tag = "R5"; end
            else tag = "R2";
            m_late = 0; m_locked = 1; m_pos = 1;
         end else tag = "R2";
      end else if (m_pos >= frame_len) begin
         if (b == sync_value) begin
            e_start = 1; e_sc = sat_inc(e_sc); m_pos = 1; tag = "R3";
         end else begin
            e_err = 1; e_ec = sat_inc(e_ec); m_locked = 0; m_pos = 0; m_late = 1; tag = "R4";
         end
      end else if (b == sync_value) begin
         e_start = 1; e_err = 1; e_sc = sat_inc(e_sc); e_ec = sat_inc(e_ec); m_pos = 1; tag = "R6";
      end else begin
         e_pay = 1; m_pos++; tag = "R3";
      end
   endtask

   task automatic compare();
      check(tag, "frame_start", frame_start, e_start);
      check(tag, "payload_valid", payload_valid, e_pay);
      check(tag, "frame_err", frame_err, e_err);
      check((e_sc == 16'hFFFF) ? "R8" : "R7", "sync_count", sync_count, e_sc);
      check((e_ec == 16'hFFFF) ? "R8" : tag, "err_count", err_count, e_ec);
   endtask

   task automatic step(input bit v, input logic [7:0] b);
      in_valid = v; in_byte = b;
      @(posedge clk);
      model(rst, v, b);
      @(negedge clk);
      compare();
   endtask

   task automatic frame(input logic [7:0] s);
      step(1, s);
      for (int i = 1; i < int'(frame_len); i++) step(1, 8'h10 + 8'(i));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog act=1 exp=0");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int sc_hold, ec_hold;
      @(negedge clk);
      rst = 1;
      step(0, 8'h00);
      step(1, 8'hA5);
      // R1 reset state
      check("R1", "sync_count", sync_count, 0);
      check("R1", "frame_start", frame_start, 0);
      rst = 0;
      // R2 hunt ignores garbage
      step(1, 8'h11); step(0, 8'h00); step(1, 8'h5A); step(1, 8'hFF);
      check("R2", "sync_count", sync_count, 0);
      // R3 good frames, with idle gaps (R10)
      frame(8'hA5); frame(8'hA5);
      step(1, 8'hA5); step(0, 8'h33); step(1, 8'h01); step(0, 8'hA5); step(0, 8'h00);
      step(1, 8'h02); step(1, 8'h03);
      step(1, 8'hA5);
      check("R3", "err_count", err_count, 0);
      step(1, 8'h20); step(1, 8'h21); step(1, 8'h22);
      // R4 missing sync, then hunting bytes, then R5 late sync
      step(1, 8'h77);
      check("R4", "err_count", err_count, 1);
      step(1, 8'h01); step(1, 8'h02); step(1, 8'h03);
      step(1, 8'hA5);
      check("R5", "err_count", err_count, 2);
      // R6 early sync
      step(1, 8'h05); step(1, 8'hA5);
      check("R6", "err_count", err_count, 3);
      frame(8'hA5); frame(8'hA5);
      // R11 sync value change at run time
      sync_value = 8'h3C;
      step(1, 8'h01); step(1, 8'h02);
      step(1, 8'hA5);
      step(1, 8'h01); step(1, 8'h02); step(1, 8'h03);
      frame(8'h3C); frame(8'h3C);
      check("R11", "frame_err", frame_err, 0);
      // R9 invalid lengths
      sc_hold = sync_count; ec_hold = err_count;
      frame_len = 8'd1;
      step(1, 8'h3C); step(1, 8'h3C); step(1, 8'h00);
      frame_len = 8'd0;
      step(1, 8'h3C); step(1, 8'h3C);
      check("R9", "sync_count", sync_count, sc_hold);
      check("R9", "err_count", err_count, ec_hold);
      frame_len = 8'd3;
      frame(8'h3C); frame(8'h3C); step(1, 8'h3C);
      // R8 saturation: long frames, sync only
      frame_len = 8'd255;
      for (int i = 0; i < 65540; i++) step(1, 8'h3C);
      check("R8", "sync_count", sync_count, 16'hFFFF);
      check("R8", "err_count", err_count, 16'hFFFF);
      step(1, 8'h3C); step(0, 8'h00);
      check("R8", "err_count", err_count, 16'hFFFF);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule